// File: doc/BRIEF.md
# Four-bit binary/decade up/down counter with preset and carry chain

This block is a single four-bit counting stage. At run time it counts either through the full binary range (0 to 15) or through one BCD decade (0 to 9), in either direction. A level-sensitive preset path loads a four-bit value from dedicated load inputs. While the preset is active, the loaded value appears on the outputs at once, without waiting for a clock edge.

Stages are chained by their carries. Each stage has an active-low carry input that works as its clock enable. Each stage also has an active-low carry output, decoded combinationally from the current count, the direction and the carry input. The carry output of one stage drives the carry input of the next, so a chain of stages counts a multi-digit decimal or hexadecimal value on one shared clock. The look-ahead carry settles within the cycle and does not wait for an edge.

Top module: `updn_dual_counter`

## Requirements
- R1: While `rst_n` is low the count output is 0. The count register is cleared as soon as `rst_n` goes low, and it stays at 0 for two rising edges after `rst_n` returns high.
- R2: On a rising edge where `cnt_en_n` is 0 and `load_en` is 0, the count moves by exactly one step in the selected direction.
- R3: On a rising edge where `cnt_en_n` is 1 and `load_en` is 0, the count keeps its value.
- R4: With `bin_mode` = 1 the count uses modulus 16. Counting up goes from 15 to 0, and counting down goes from 0 to 15.
- R5: With `bin_mode` = 0 the count uses modulus 10. Counting up goes from 9 to 0, and counting down goes from 0 to 9.
- R6: While `load_en` is 1, `count` equals `load_val` in the same cycle, with no clock edge needed, and clock edges do not advance the count.
- R7: After `load_en` falls, the count holds the value of `load_val` seen at the last rising edge on which `load_en` was 1, until the count is next enabled.
- R8: In decade mode a loaded value from 10 to 15 is kept. The next up step from any such value gives 0, and the next down step gives the value minus one.
- R9: `carry_n` is 0 only when `cnt_en_n` is 0 and the displayed count is at its terminal value: 15 (binary, `up_mode` = 1), 9 (decade, `up_mode` = 1) or 0 (`up_mode` = 0). Otherwise `carry_n` is 1. A change on `cnt_en_n` reaches `carry_n` without a clock edge.
- R10: Two stages, with the first stage's `carry_n` driving the second stage's `cnt_en_n`, count 00 to 99 in decade mode and 00 to FF in binary mode in both directions, and they wrap at the ends of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_en_n | input | 1 | Active-low carry input / count enable |
| bin_mode | input | 1 | 1 = modulus 16, 0 = modulus 10 |
| up_mode | input | 1 | 1 = count up, 0 = count down |
| load_en | input | 1 | Level-sensitive preset enable |
| load_val | input | 4 | Preset value |
| count | output | 4 | Current count (shows `load_val` while `load_en` is 1) |
| carry_n | output | 1 | Active-low carry output for cascading |

## Verification
A preset and a count enable can fall in the same cycle. The bench holds `cnt_en_n` low while it raises `load_en` mid-count. It then expects the count to follow `load_val` at once and to stop advancing. It also expects the carry output to be decoded from the loaded value rather than from the register.

The second case is terminal count on the low stage. Here the high stage's enable and the low stage's wrap land on the same edge, and the high digit must step on exactly that edge. The reference model predicts both digits and both carries every clock through full decade and hex sweeps in both directions, and across a preset of an out-of-range decade value.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;
  localparam int DIGIT_W  = 4;
  localparam int HEX_TOP  = (1 << DIGIT_W) - 1;
  localparam int DEC_TOP  = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic {
    MOD_DEC = 1'b0,
    MOD_BIN = 1'b1
  } modulus_e;
endpackage

// File: rtl/updn_rst_sync.sv
module updn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/updn_step.sv
module updn_step
  import updn_cnt_pkg::*;
(
  input  digit_t cur,
  input  logic   bin_mode,
  input  logic   up_mode,
  output digit_t nxt
);
  localparam digit_t TOP_BIN = digit_t'(HEX_TOP);
  localparam digit_t TOP_DEC = digit_t'(DEC_TOP);

  digit_t top_val;
  logic   at_or_above_top;

  always_comb begin
    top_val         = (modulus_e'(bin_mode) == MOD_BIN) ? TOP_BIN : TOP_DEC;
    at_or_above_top = (cur >= top_val);
    nxt             = cur;
    if (up_mode) begin
      if (at_or_above_top) begin
        nxt = '0;
      end else begin
        nxt = cur + digit_t'(1);
      end
    end else begin
      if (cur == '0) begin
        nxt = top_val;
      end else begin
        nxt = cur - digit_t'(1);
      end
    end
  end
endmodule

// File: rtl/updn_carry.sv
module updn_carry
  import updn_cnt_pkg::*;
(
  input  digit_t shown,
  input  logic   bin_mode,
  input  logic   up_mode,
  input  logic   cnt_en_n,
  output logic   carry_n
);
  localparam digit_t TOP_BIN = digit_t'(HEX_TOP);
  localparam digit_t TOP_DEC = digit_t'(DEC_TOP);

  logic terminal;

  always_comb begin
    if (up_mode) begin
      terminal = (modulus_e'(bin_mode) == MOD_BIN) ? (shown == TOP_BIN)
                                                   : (shown == TOP_DEC);
    end else begin
      terminal = (shown == '0);
    end
    carry_n = ~(terminal & ~cnt_en_n);
  end
endmodule

// File: rtl/updn_dual_counter.sv
module updn_dual_counter
  import updn_cnt_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en_n,
  input  logic               bin_mode,
  input  logic               up_mode,
  input  logic               load_en,
  input  logic [DIGIT_W-1:0] load_val,
  output logic [DIGIT_W-1:0] count,
  output logic               carry_n
);
  logic   rst_int_n;
  logic   advance;
  digit_t state_q;
  digit_t state_d;
  digit_t step_val;
  digit_t shown;

  updn_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  updn_step u_step (
    .cur      (state_q),
    .bin_mode (bin_mode),
    .up_mode  (up_mode),
    .nxt      (step_val)
  );

  assign advance = ~cnt_en_n & ~load_en;

  always_comb begin
    state_d = state_q;
    if (load_en) begin
      state_d = load_val;
    end else if (advance) begin
      state_d = step_val;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  assign shown = load_en ? load_val : state_q;

  updn_carry u_carry (
    .shown    (shown),
    .bin_mode (bin_mode),
    .up_mode  (up_mode),
    .cnt_en_n (cnt_en_n),
    .carry_n  (carry_n)
  );

  assign count = shown;
endmodule

// File: rtl/updn_dual_counter_chk.sv
module updn_dual_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_en_n,
  input logic       bin_mode,
  input logic       up_mode,
  input logic       load_en,
  input logic [3:0] load_val,
  input logic [3:0] count,
  input logic       carry_n
);
  // R3: disabled count keeps its value
  a_r3_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_n && !load_en) |=> (load_en || count == $past(count)));

  // R6: preset shows on the outputs
  a_r6_preset_visible: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (count == load_val));

  // R9: carry held high while enable is inactive
  a_r9_carry_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en_n |-> carry_n);

  // R9: carry low at zero when counting down
  a_r9_carry_down_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_n && !up_mode && count == 4'd0) |-> !carry_n);

  // R4: binary wrap upward
  a_r4_bin_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_mode && up_mode && !cnt_en_n && !load_en && count == 4'd15)
      |=> (load_en || count == 4'd0));

  // R8: out-of-range decade value steps up to zero
  a_r8_dec_over_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!bin_mode && up_mode && !cnt_en_n && !load_en && count > 4'd9)
      |=> (load_en || count == 4'd0));

  // R2: one step up in binary when not at the top
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_mode && up_mode && !cnt_en_n && !load_en && count != 4'd15)
      |=> (load_en || count == $past(count) + 4'd1));
endmodule

bind updn_dual_counter updn_dual_counter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en_n (cnt_en_n),
  .bin_mode (bin_mode),
  .up_mode  (up_mode),
  .load_en  (load_en),
  .load_val (load_val),
  .count    (count),
  .carry_n  (carry_n)
);

// File: tb/updn_dual_counter_tb.sv
module updn_dual_counter_tb;
  localparam time HALF = 4ns;

  logic       clk;
  logic       rst_n;
  logic       cin_lo;
  logic       bin_mode;
  logic       up_mode;
  logic       load_en;
  logic [3:0] jam_lo;
  logic [3:0] jam_hi;
  logic [3:0] q_lo;
  logic [3:0] q_hi;
  logic       co_lo;
  logic       co_hi;

  int    total;
  int    bad;
  int    m_lo;
  int    m_hi;
  bit    done;
  string phase;

  updn_dual_counter u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cin_lo), .bin_mode(bin_mode),
    .up_mode(up_mode), .load_en(load_en), .load_val(jam_lo),
    .count(q_lo), .carry_n(co_lo)
  );

  updn_dual_counter u_hi (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(co_lo), .bin_mode(bin_mode),
    .up_mode(up_mode), .load_en(load_en), .load_val(jam_hi),
    .count(q_hi), .carry_n(co_hi)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  function automatic int modulus();
    return bin_mode ? 16 : 10;
  endfunction

  function automatic int step(int v);
    int m;
    m = modulus();
    if (up_mode) return (v >= m - 1) ? 0 : v + 1;
    return (v == 0) ? m - 1 : v - 1;
  endfunction

  function automatic bit at_end(int v);
    if (up_mode) return v == modulus() - 1;
    return v == 0;
  endfunction

  function automatic int show_lo();
    return load_en ? int'(jam_lo) : m_lo;
  endfunction

  function automatic int show_hi();
    return load_en ? int'(jam_hi) : m_hi;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
    end
  endtask

  // reference model and per-clock comparison
  always @(posedge clk) begin
    bit lo_carry_exp;
    if (!rst_n) begin
      m_lo = 0;
      m_hi = 0;
    end else if (load_en) begin
      m_lo = int'(jam_lo);
      m_hi = int'(jam_hi);
    end else begin
      lo_carry_exp = !cin_lo && at_end(m_lo);
      if (!cin_lo) m_lo = step(m_lo);
      if (lo_carry_exp) m_hi = step(m_hi);
    end
    #2;
    chk("R10 low digit", int'(q_lo), show_lo());
    chk("R10 high digit", int'(q_hi), show_hi());
    chk("R9 low carry", int'(co_lo), (!cin_lo && at_end(show_lo())) ? 0 : 1);
    chk("R9 high carry", int'(co_hi), (!co_lo && at_end(show_hi())) ? 0 : 1);
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic preset(int lo, int hi);
    @(negedge clk);
    load_en = 1'b1;
    jam_lo  = 4'(lo);
    jam_hi  = 4'(hi);
    #1;
    chk("R6 async preset low", int'(q_lo), lo);
    chk("R6 async preset high", int'(q_hi), hi);
    cycles(2);
    load_en = 1'b0;
  endtask

  initial begin
    total = 0; bad = 0; done = 0; m_lo = 0; m_hi = 0;
    phase = "reset";
    rst_n = 1'b0; cin_lo = 1'b1; bin_mode = 1'b1; up_mode = 1'b1;
    load_en = 1'b0; jam_lo = 4'd0; jam_hi = 4'd0;
    cycles(3);
    chk("R1 reset low digit", int'(q_lo), 0);
    chk("R1 reset high digit", int'(q_hi), 0);
    rst_n = 1'b1;
    cycles(4);

    phase = "R10 decade up";
    bin_mode = 1'b0; up_mode = 1'b1; cin_lo = 1'b0;
    cycles(103);
    phase = "R10 decade down";
    up_mode = 1'b0;
    cycles(104);
    phase = "R4 hex up";
    bin_mode = 1'b1; up_mode = 1'b1;
    cycles(260);
    phase = "R4 hex down";
    up_mode = 1'b0;
    cycles(260);

    phase = "R3 disabled";
    cin_lo = 1'b1;
    cycles(6);
    chk("R3 held low digit", int'(q_lo), m_lo);

    phase = "R6 preset while enabled";
    cin_lo = 1'b0;
    preset(5, 3);
    phase = "R7 hold after preset";
    cin_lo = 1'b1;
    cycles(3);
    chk("R7 low digit held", int'(q_lo), 5);
    chk("R7 high digit held", int'(q_hi), 3);
    phase = "R2 resume";
    bin_mode = 1'b1; up_mode = 1'b1; cin_lo = 1'b0;
    cycles(1);
    chk("R2 one step", int'(q_lo), 6);

    phase = "R8 decade over-range up";
    cin_lo = 1'b1; bin_mode = 1'b0;
    preset(12, 0);
    cin_lo = 1'b0;
    cycles(1);
    chk("R8 12 up gives 0", int'(q_lo), 0);
    phase = "R8 decade over-range down";
    cin_lo = 1'b1; up_mode = 1'b0;
    preset(13, 0);
    cin_lo = 1'b0;
    cycles(1);
    chk("R8 13 down gives 12", int'(q_lo), 12);

    phase = "R9 combinational carry";
    cin_lo = 1'b1; up_mode = 1'b1;
    preset(9, 4);
    #1;
    chk("R9 carry high while disabled", int'(co_lo), 1);
    cin_lo = 1'b0;
    #1;
    chk("R9 carry low without edge", int'(co_lo), 0);
    cycles(1);
    chk("R5 decade wrap 9 to 0", int'(q_lo), 0);
    chk("R10 high digit steps on wrap", int'(q_hi), 5);

    phase = "R5 decade down wrap";
    up_mode = 1'b0;
    cycles(1);
    chk("R5 decade 0 down to 9", int'(q_lo), 9);
    cycles(30);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 2 * HALF);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule